// File: doc/BRIEF.md
# Core Test Wrapper Instruction Register

This block is the instruction register of a core test wrapper. A tester shifts an opcode into it one bit at a time through a serial input. A separate strobe then commits that opcode to an active stage. The active opcode sets the mode, and the mode is decoded into the control lines that steer the boundary cells, the bypass path and the signature logic around a wrapped core. The same register can be loaded back from the active opcode, so the current setting can be read out serially.

On top of the usual bypass, intest and extest modes, two modes observe the core while it runs normally. In the snooping mode the boundary cells stay transparent while they copy traffic to the signature compressors. The signature-out mode asks the signature logic to unload its accumulated result.

The active stage is a state machine whose states are MODE_FUNC, MODE_BYPASS, MODE_INTEST, MODE_EXTEST, MODE_SNOOP and MODE_SIGOUT. It has three transitions:
- reset: any state goes to MODE_FUNC.
- update load: on a clock edge where select and update are both high, the machine moves to the state decoded from the shift stage.
- hold: on every other edge the machine stays where it is.

Top module: `cwir_top`

## Requirements
- R1: When select and shift are both high on a rising clock edge, the 4-bit shift stage moves one place toward bit 0 and takes the serial input into bit 3. While select is high, the serial output shows shift-stage bit 0, so an opcode is entered least significant bit first.
- R2: In every other case the shift stage holds its value, except for the capture load in R3.
- R3: When select and capture are high and shift is low on an edge, the shift stage loads the opcode of the active mode. Unknown opcodes have already been replaced by 0000 when they were committed, so 0000 is loaded for them.
- R4: The decoded control lines change only in the cycle that follows an edge where select and update were both high.
- R5: The active-low reset, which is asynchronous, clears the shift stage, the active opcode (0000, functional mode) and the bypass bit. While in functional mode every control line is 0.
- R6: Opcode 1101 (snooping) drives snoop_en=1 and drives core_scan_en, cell_hold_en, cell_shift_en and sig_unload to 0.
- R7: Opcode 1110 (signature out) drives sig_unload=1. All other lines, which carry no meaning in this mode, are driven 0.
- R8: Opcode 0001 drives bypass_mode=1. Opcode 0010 drives intest_mode, cell_hold_en, cell_shift_en and core_scan_en to 1. Opcode 0011 drives extest_mode, cell_hold_en and cell_shift_en to 1 with core_scan_en=0. At most one of the mode lines and the snooping and unload lines is high at a time.
- R9: Every opcode outside 0001, 0010, 0011, 1101 and 1110 decodes as 0000, the functional mode.
- R10: While select is low, the serial output is a 1-bit bypass flop. On shift this flop takes the serial input, and on capture without shift it takes 0.
- R11: An update strobe given while select is low has no effect on the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Wrapper clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset |
| cap_strb | input | 1 | Capture strobe |
| sel_instr | input | 1 | Selects the instruction path (high) or the bypass path (low) |
| shift_strb | input | 1 | Shift strobe |
| upd_strb | input | 1 | Update strobe |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| core_scan_en | output | 1 | Scan enable for the wrapped core |
| cell_hold_en | output | 1 | Boundary cells hold or apply their value |
| cell_shift_en | output | 1 | Boundary cells on the serial shift path |
| snoop_en | output | 1 | Boundary cells copy live traffic to the signature logic |
| sig_unload | output | 1 | Signature registers load and unload |
| bypass_mode | output | 1 | Bypass mode active |
| intest_mode | output | 1 | Internal test mode active |
| extest_mode | output | 1 | External test mode active |

## Verification
The bench builds the block with its default opcode width of 4, so all sixteen opcodes can be reached. It commits each of them in turn, which covers every decode and every unknown code that falls back to functional mode. Because the width is small, each opcode takes four shift cycles, and the capture path, the bypass flop and the ignored update can be exercised between loads. A reset in the middle of the run, while a test mode is active, confirms the return to the functional default.

// File: rtl/cwir_pkg.sv
package cwir_pkg;

    localparam int unsigned OPC_W_DEF = 4;

    localparam logic [3:0] OPC_FUNC   = 4'b0000;
    localparam logic [3:0] OPC_BYPASS = 4'b0001;
    localparam logic [3:0] OPC_INTEST = 4'b0010;
    localparam logic [3:0] OPC_EXTEST = 4'b0011;
    localparam logic [3:0] OPC_SNOOP  = 4'b1101;
    localparam logic [3:0] OPC_SIGOUT = 4'b1110;

    typedef enum logic [2:0] {
        MODE_FUNC,
        MODE_BYPASS,
        MODE_INTEST,
        MODE_EXTEST,
        MODE_SNOOP,
        MODE_SIGOUT
    } wmode_e;

    typedef struct packed {
        logic scan_en;
        logic hold_en;
        logic bnd_shift;
        logic snoop;
        logic sig_out;
        logic byp;
        logic intest;
        logic extest;
    } wctl_t;

endpackage

// File: rtl/cwir_shift_stage.sv
module cwir_shift_stage
    import cwir_pkg::*;
#(
    parameter int unsigned W = OPC_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         shift,
    input  logic         capture,
    input  logic         si,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d;

    always_comb begin
        q_d = q;
        if (sel && shift) begin
            q_d = {si, q[W-1:1]};
        end else if (sel && capture) begin
            q_d = cap_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_d;
        end
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift) |=> (q == {$past(si), $past(q[W-1:1])}));

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || (!shift && !capture)) |=> $stable(q));

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture && !shift) |=> (q == $past(cap_val)));

endmodule

// File: rtl/cwir_bypass_bit.sv
module cwir_bypass_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic shift,
    input  logic capture,
    input  logic si,
    output logic q
);

    logic q_d;

    always_comb begin
        q_d = q;
        if (!sel && shift) begin
            q_d = si;
        end else if (!sel && capture) begin
            q_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= q_d;
        end
    end

    // R10
    byp_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && shift) |=> (q == $past(si)));

    // R10
    byp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && capture && !shift) |=> (q == 1'b0));

endmodule

// File: rtl/cwir_mode_fsm.sv
module cwir_mode_fsm
    import cwir_pkg::*;
#(
    parameter int unsigned W = OPC_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] opc_in,
    output logic [W-1:0] opc_act,
    output wctl_t        ctl
);

    localparam logic [W-1:0] K_FUNC   = W'(OPC_FUNC);
    localparam logic [W-1:0] K_BYPASS = W'(OPC_BYPASS);
    localparam logic [W-1:0] K_INTEST = W'(OPC_INTEST);
    localparam logic [W-1:0] K_EXTEST = W'(OPC_EXTEST);
    localparam logic [W-1:0] K_SNOOP  = W'(OPC_SNOOP);
    localparam logic [W-1:0] K_SIGOUT = W'(OPC_SIGOUT);

    wmode_e mode_q;
    wmode_e mode_d;
    wmode_e mode_dec;

    always_comb begin
        mode_dec = MODE_FUNC;
        unique case (opc_in)
            K_BYPASS: mode_dec = MODE_BYPASS;
            K_INTEST: mode_dec = MODE_INTEST;
            K_EXTEST: mode_dec = MODE_EXTEST;
            K_SNOOP:  mode_dec = MODE_SNOOP;
            K_SIGOUT: mode_dec = MODE_SIGOUT;
            default:  mode_dec = MODE_FUNC;
        endcase
    end

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d = mode_dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_FUNC;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        ctl     = '0;
        opc_act = K_FUNC;
        unique case (mode_q)
            MODE_FUNC: begin
                opc_act = K_FUNC;
            end
            MODE_BYPASS: begin
                opc_act  = K_BYPASS;
                ctl.byp  = 1'b1;
            end
            MODE_INTEST: begin
                opc_act       = K_INTEST;
                ctl.intest    = 1'b1;
                ctl.hold_en   = 1'b1;
                ctl.bnd_shift = 1'b1;
                ctl.scan_en   = 1'b1;
            end
            MODE_EXTEST: begin
                opc_act       = K_EXTEST;
                ctl.extest    = 1'b1;
                ctl.hold_en   = 1'b1;
                ctl.bnd_shift = 1'b1;
            end
            MODE_SNOOP: begin
                opc_act   = K_SNOOP;
                ctl.snoop = 1'b1;
            end
            MODE_SIGOUT: begin
                opc_act     = K_SIGOUT;
                ctl.sig_out = 1'b1;
            end
            default: begin
                opc_act = K_FUNC;
                ctl     = '0;
            end
        endcase
    end

    // R4
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ctl));

    // R5
    reset_func_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl == '0));

    // R6
    snoop_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && opc_in == K_SNOOP) |=>
        (ctl.snoop && !ctl.scan_en && !ctl.hold_en && !ctl.bnd_shift && !ctl.sig_out));

    // R7
    sigout_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && opc_in == K_SIGOUT) |=> ctl.sig_out);

    // R8
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.byp, ctl.intest, ctl.extest, ctl.snoop, ctl.sig_out}));

endmodule

// File: rtl/cwir_top.sv
module cwir_top
    import cwir_pkg::*;
#(
    parameter int unsigned OPC_W = OPC_W_DEF
) (
    input  logic wr_clk,
    input  logic wr_rst_n,
    input  logic cap_strb,
    input  logic sel_instr,
    input  logic shift_strb,
    input  logic upd_strb,
    input  logic ser_in,
    output logic ser_out,
    output logic core_scan_en,
    output logic cell_hold_en,
    output logic cell_shift_en,
    output logic snoop_en,
    output logic sig_unload,
    output logic bypass_mode,
    output logic intest_mode,
    output logic extest_mode
);

    logic [OPC_W-1:0] sr_q;
    logic [OPC_W-1:0] opc_act;
    logic             byp_q;
    logic             upd_load;
    wctl_t            ctl;

    assign upd_load = sel_instr && upd_strb;

    cwir_shift_stage #(.W(OPC_W)) u_shift (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .sel     (sel_instr),
        .shift   (shift_strb),
        .capture (cap_strb),
        .si      (ser_in),
        .cap_val (opc_act),
        .q       (sr_q)
    );

    cwir_mode_fsm #(.W(OPC_W)) u_mode (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .load    (upd_load),
        .opc_in  (sr_q),
        .opc_act (opc_act),
        .ctl     (ctl)
    );

    cwir_bypass_bit u_byp (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .sel     (sel_instr),
        .shift   (shift_strb),
        .capture (cap_strb),
        .si      (ser_in),
        .q       (byp_q)
    );

    assign ser_out       = sel_instr ? sr_q[0] : byp_q;
    assign core_scan_en  = ctl.scan_en;
    assign cell_hold_en  = ctl.hold_en;
    assign cell_shift_en = ctl.bnd_shift;
    assign snoop_en      = ctl.snoop;
    assign sig_unload    = ctl.sig_out;
    assign bypass_mode   = ctl.byp;
    assign intest_mode   = ctl.intest;
    assign extest_mode   = ctl.extest;

    // R11
    upd_ignored_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (upd_strb && !sel_instr) |=> $stable(opc_act));

endmodule

// File: tb/cwir_top_tb_top.sv
module cwir_top_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic cap = 1'b0, sel = 1'b0, sh = 1'b0, upd = 1'b0, din = 1'b0;
    logic so, se, hold, bsh, snp, sig, byp, itst, etst;

    cwir_top dut_i (
        .wr_clk(clk), .wr_rst_n(rst_n), .cap_strb(cap), .sel_instr(sel),
        .shift_strb(sh), .upd_strb(upd), .ser_in(din), .ser_out(so),
        .core_scan_en(se), .cell_hold_en(hold), .cell_shift_en(bsh),
        .snoop_en(snp), .sig_unload(sig), .bypass_mode(byp),
        .intest_mode(itst), .extest_mode(etst)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R5";
    int m_sr = 0, m_op = 0, m_byp = 0;

    function automatic int canon(int v);
        if (v == 1 || v == 2 || v == 3 || v == 13 || v == 14) return v;
        return 0;
    endfunction

    task automatic chk1(string nm, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (op=%0d)", cur_req, nm, act, exp, m_op);
        end
    endtask

    task automatic compare_all();
        logic e_se, e_hold, e_bsh, e_snp, e_sig, e_byp, e_int, e_ext, e_so;
        e_se = 0; e_hold = 0; e_bsh = 0; e_snp = 0; e_sig = 0; e_byp = 0; e_int = 0; e_ext = 0;
        case (m_op)
            1:  e_byp = 1;
            2:  begin e_int = 1; e_hold = 1; e_bsh = 1; e_se = 1; end
            3:  begin e_ext = 1; e_hold = 1; e_bsh = 1; end
            13: e_snp = 1;
            14: e_sig = 1;
            default: ;
        endcase
        e_so = sel ? logic'(m_sr[0]) : logic'(m_byp[0]);
        chk1("ser_out", so, e_so);
        chk1("core_scan_en", se, e_se);
        chk1("cell_hold_en", hold, e_hold);
        chk1("cell_shift_en", bsh, e_bsh);
        chk1("snoop_en", snp, e_snp);
        chk1("sig_unload", sig, e_sig);
        chk1("bypass_mode", byp, e_byp);
        chk1("intest_mode", itst, e_int);
        chk1("extest_mode", etst, e_ext);
    endtask

    task automatic step(logic c, logic s, logic h, logic u, logic d);
        int nsr, nop, nbyp;
        @(negedge clk);
        cap = c; sel = s; sh = h; upd = u; din = d;
        @(posedge clk);
        nsr = m_sr; nop = m_op; nbyp = m_byp;
        if (s && h) nsr = (m_sr >> 1) | (int'(d) << 3);
        else if (s && c) nsr = m_op;
        if (s && u) nop = canon(m_sr);
        if (!s && h) nbyp = int'(d);
        else if (!s && c) nbyp = 0;
        m_sr = nsr; m_op = nop; m_byp = nbyp;
        #1;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cap = 0; sel = 0; sh = 0; upd = 0; din = 0;
        m_sr = 0; m_op = 0; m_byp = 0;
        #1;
        compare_all();
        @(posedge clk);
        #1;
        compare_all();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic shift_op(int op);
        for (int b = 0; b < 4; b++) step(0, 1, 1, 0, logic'((op >> b) & 1));
    endtask

    task automatic load_op(int op);
        shift_op(op);
        step(0, 1, 0, 1, 0);
        step(0, 1, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R5: reset state
        cur_req = "R5";
        do_reset();
        step(0, 0, 0, 0, 0);

        // R1 and R4: shifting does not move outputs until update
        cur_req = "R4";
        shift_op(13);
        cur_req = "R6";
        step(0, 1, 0, 1, 0);
        step(0, 1, 0, 0, 0);

        // R2: hold when strobes are not both high
        cur_req = "R2";
        step(0, 1, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 1, 0, 0, 0);

        // R1: serial output walks out the shifted pattern
        cur_req = "R1";
        shift_op(6);
        shift_op(9);

        // R3: capture of the active opcode, then shift it out
        cur_req = "R3";
        step(1, 1, 0, 0, 0);
        shift_op(0);

        // R7
        cur_req = "R7";
        load_op(14);

        // R8 and R9: sweep every opcode
        for (int op = 0; op < 16; op++) begin
            cur_req = (canon(op) == op && op != 0) ? "R8" : "R9";
            if (op == 13) cur_req = "R6";
            if (op == 14) cur_req = "R7";
            load_op(op);
            cur_req = "R3";
            step(1, 1, 0, 0, 0);
        end

        // R11: update with select low ignored
        cur_req = "R8";
        load_op(3);
        cur_req = "R11";
        shift_op(1);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);

        // R10: bypass bit path
        cur_req = "R10";
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 1);
        step(1, 0, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0);

        // R5: reset in the middle of intest
        cur_req = "R8";
        load_op(2);
        cur_req = "R5";
        do_reset();
        step(0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule